// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Logic

This block is the interrupt engine of a two-port GPIO expander with a configurable number of pins per port. It watches both port pin vectors and passes them through a synchronizer first. When the synchronized value of either port moves away from the value it stored last, the block evaluates both ports. For each pin it picks one comparison: against the pin's own previous value, or against a per-pin reference value. Comparison results go through two masks, an interrupt enable mask and a direction mask, and the result becomes the port's flag register. The first event on a quiet port also loads that port's capture register with the pin state.

Each port has its own interrupt output, and the active level is programmable. In mirror mode both outputs report the OR of the two ports. The register file around the block raises a read strobe when software reads a port's pin register or capture register. That strobe clears the port's flags and releases its interrupt output.

Top module: `gpio_ioc_core`

## Requirements
- R1: While reset is asserted and until the first evaluation or read strobe, both flag registers and both capture registers are zero, and both interrupt outputs are 1, whatever the polarity input is.
- R2: Each pin vector passes through a two-stage synchronizer. A pin change driven before rising edge n shows in the flag register after rising edge n+2 and not before.
- R3: For each pin, a mode bit of 0 compares the new value with the stored previous value, and a mode bit of 1 compares it with that pin's reference bit. The raw flag is 1 when the two differ.
- R4: A raw flag reaches the flag register only when the pin's enable bit is 1 and its direction bit is 1 (1 = input).
- R5: Evaluation happens only on a cycle in which the synchronized value of port A or port B differs from the stored value, and the stored value then takes the new value. Changes to the mode, reference, enable or direction inputs alone do not alter the flags or the outputs.
- R6: On every evaluation of a port, its flag register is replaced by the newly computed flags, so a port with no new mismatches ends with zero flags.
- R7: A port's capture register loads the synchronized pin vector only when its previous flags were zero and the new flags are nonzero. Later events leave the capture register unchanged.
- R8: On an evaluation, a port's interrupt output takes the polarity input's value if that port's enable mask is nonzero and its new flags are nonzero. Otherwise it takes the inverse of the polarity input. Between evaluations and read strobes the outputs hold their levels.
- R9: With mirror set, an evaluation drives both interrupt outputs active when either port is pending, and inactive otherwise.
- R10: A read strobe for a port clears that port's flags and drives its interrupt output to the inverse of the polarity input. With mirror set, a strobe for either port drives both outputs inactive and leaves the other port's flags unchanged.
- R11: When a read strobe and an evaluation of the same port fall in the same cycle, the evaluation wins. The old flags count as already cleared, so a nonzero result also loads the capture register.
- R12: A port whose enable mask is all zero is not evaluated, and its flags and capture register hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_a_i | input | PORT_W | Port A pin levels (asynchronous) |
| pins_b_i | input | PORT_W | Port B pin levels (asynchronous) |
| irq_en_a_i | input | PORT_W | Port A per-pin interrupt enable |
| irq_en_b_i | input | PORT_W | Port B per-pin interrupt enable |
| cmp_ref_sel_a_i | input | PORT_W | Port A compare mode, 1 = against reference |
| cmp_ref_sel_b_i | input | PORT_W | Port B compare mode, 1 = against reference |
| ref_a_i | input | PORT_W | Port A reference values |
| ref_b_i | input | PORT_W | Port B reference values |
| dir_in_a_i | input | PORT_W | Port A direction, 1 = input |
| dir_in_b_i | input | PORT_W | Port B direction, 1 = input |
| irq_pol_i | input | 1 | Active level of the interrupt outputs |
| irq_mirror_i | input | 1 | Both outputs report either port |
| rd_clr_a_i | input | 1 | Read strobe of port A pin or capture register |
| rd_clr_b_i | input | 1 | Read strobe of port B pin or capture register |
| flags_a_o | output | PORT_W | Port A flag register |
| flags_b_o | output | PORT_W | Port B flag register |
| cap_a_o | output | PORT_W | Port A capture register |
| cap_b_o | output | PORT_W | Port B capture register |
| irq_a_o | output | 1 | Port A interrupt output |
| irq_b_o | output | 1 | Port B interrupt output |

## Verification
A sequence of pin vectors first checks change-against-previous on single and multiple bits. The same sequence then checks a port that stops changing and loses its flags while its stale capture is kept, and a vector that mixes reference compares and previous compares on one port, which shows whether the mode is chosen per pin. Directed patterns then toggle every pin under partial enable and direction masks, and alter only the configuration to show that no evaluation follows. Further patterns change only port B with mirror set and then with inverted polarity, and land a read strobe in the same cycle as an evaluation, which separates event-over-clear priority from clear-over-event.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {
    PIN_HOLD  = 2'd0,
    PIN_EVAL  = 2'd1,
    PIN_CLEAR = 2'd2
  } pin_op_e;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ioc_port_eval.sv
module ioc_port_eval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval_i,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] dir_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] cap_o,
  output logic         act_nxt_o
);
  logic [W-1:0] flags_q, flags_d, cap_q, cap_d;
  logic [W-1:0] raw, newf, old_eff;
  logic         run, flags_we, cap_we;

  always_comb begin
    run      = eval_i && (|en_i);
    raw      = ((smp_i ^ prev_i) & ~mode_i) | ((smp_i ^ ref_i) & mode_i);
    newf     = raw & en_i & dir_i;
    old_eff  = rd_clr_i ? '0 : flags_q;
    flags_we = run || rd_clr_i;
    cap_we   = run && (old_eff == '0) && (|newf);
    flags_d  = run ? newf : '0;
    cap_d    = smp_i;
    act_nxt_o = (|en_i) && (|(flags_we ? flags_d : flags_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cap_q   <= '0;
    end else begin
      if (flags_we) flags_q <= flags_d;
      if (cap_we)   cap_q   <= cap_d;
    end
  end

  assign flags_o = flags_q;
  assign cap_o   = cap_q;

  // R5: flags move only on evaluation or read strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_i && !rd_clr_i) |=> $stable(flags_q));
  // R10: a lone read strobe empties the flags
  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !eval_i) |=> (flags_q == '0));
  // R4: flags set only on enabled input pins
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && (|en_i)) |=> ((flags_q & ~$past(en_i & dir_i)) == '0));
  // R7: capture frozen while flags pending
  p_cap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags_q) && !rd_clr_i) |=> $stable(cap_q));
endmodule

// File: rtl/ioc_pin_drive.sv
module ioc_pin_drive
  import gpio_ioc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic change_i,
  input  logic act_a_i,
  input  logic act_b_i,
  input  logic rd_a_i,
  input  logic rd_b_i,
  input  logic pol_i,
  input  logic mirror_i,
  output logic irq_a_o,
  output logic irq_b_o
);
  pin_op_e op;
  logic    irq_a_q, irq_b_q, irq_a_d, irq_b_d, pins_we;

  always_comb begin
    if (change_i)            op = PIN_EVAL;
    else if (rd_a_i || rd_b_i) op = PIN_CLEAR;
    else                     op = PIN_HOLD;

    irq_a_d = irq_a_q;
    irq_b_d = irq_b_q;
    pins_we = 1'b0;
    case (op)
      PIN_EVAL: begin
        pins_we = 1'b1;
        if (mirror_i) begin
          irq_a_d = (act_a_i || act_b_i) ? pol_i : ~pol_i;
          irq_b_d = irq_a_d;
        end else begin
          irq_a_d = act_a_i ? pol_i : ~pol_i;
          irq_b_d = act_b_i ? pol_i : ~pol_i;
        end
      end
      PIN_CLEAR: begin
        pins_we = 1'b1;
        if (rd_a_i || (mirror_i && rd_b_i)) irq_a_d = ~pol_i;
        if (rd_b_i || (mirror_i && rd_a_i)) irq_b_d = ~pol_i;
      end
      default: pins_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a_q <= 1'b1;
      irq_b_q <= 1'b1;
    end else if (pins_we) begin
      irq_a_q <= irq_a_d;
      irq_b_q <= irq_b_d;
    end
  end

  assign irq_a_o = irq_a_q;
  assign irq_b_o = irq_b_q;

  // R9: mirrored evaluation leaves the outputs equal
  p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (change_i && mirror_i) |=> (irq_a_o == irq_b_o));
  // R8: outputs hold between events
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!change_i && !rd_a_i && !rd_b_i) |=> ($stable(irq_a_o) && $stable(irq_b_o)));
endmodule

// File: rtl/gpio_ioc_core.sv
module gpio_ioc_core
  import gpio_ioc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins_a_i,
  input  logic [PORT_W-1:0] pins_b_i,
  input  logic [PORT_W-1:0] irq_en_a_i,
  input  logic [PORT_W-1:0] irq_en_b_i,
  input  logic [PORT_W-1:0] cmp_ref_sel_a_i,
  input  logic [PORT_W-1:0] cmp_ref_sel_b_i,
  input  logic [PORT_W-1:0] ref_a_i,
  input  logic [PORT_W-1:0] ref_b_i,
  input  logic [PORT_W-1:0] dir_in_a_i,
  input  logic [PORT_W-1:0] dir_in_b_i,
  input  logic              irq_pol_i,
  input  logic              irq_mirror_i,
  input  logic              rd_clr_a_i,
  input  logic              rd_clr_b_i,
  output logic [PORT_W-1:0] flags_a_o,
  output logic [PORT_W-1:0] flags_b_o,
  output logic [PORT_W-1:0] cap_a_o,
  output logic [PORT_W-1:0] cap_b_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  logic [PORT_W-1:0] pin_raw [NUM_PORTS];
  logic [PORT_W-1:0] smp     [NUM_PORTS];
  logic [PORT_W-1:0] prev_q  [NUM_PORTS];
  logic [PORT_W-1:0] en_v    [NUM_PORTS];
  logic [PORT_W-1:0] mode_v  [NUM_PORTS];
  logic [PORT_W-1:0] ref_v   [NUM_PORTS];
  logic [PORT_W-1:0] dir_v   [NUM_PORTS];
  logic [PORT_W-1:0] flg_v   [NUM_PORTS];
  logic [PORT_W-1:0] cap_v   [NUM_PORTS];
  logic [NUM_PORTS-1:0] rd_v, act_v;
  logic change;

  assign pin_raw[0] = pins_a_i;        assign pin_raw[1] = pins_b_i;
  assign en_v[0]    = irq_en_a_i;      assign en_v[1]    = irq_en_b_i;
  assign mode_v[0]  = cmp_ref_sel_a_i; assign mode_v[1]  = cmp_ref_sel_b_i;
  assign ref_v[0]   = ref_a_i;         assign ref_v[1]   = ref_b_i;
  assign dir_v[0]   = dir_in_a_i;      assign dir_v[1]   = dir_in_b_i;
  assign rd_v       = {rd_clr_b_i, rd_clr_a_i};

  always_comb begin
    change = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) change = change || (smp[p] != prev_q[p]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ioc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_raw[p]), .dout(smp[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_q[p] <= '0;
      else if (change) prev_q[p] <= smp[p];
    end

    ioc_port_eval #(.W(PORT_W)) u_eval (
      .clk(clk), .rst_n(rst_n), .eval_i(change), .smp_i(smp[p]),
      .prev_i(prev_q[p]), .en_i(en_v[p]), .mode_i(mode_v[p]),
      .ref_i(ref_v[p]), .dir_i(dir_v[p]), .rd_clr_i(rd_v[p]),
      .flags_o(flg_v[p]), .cap_o(cap_v[p]), .act_nxt_o(act_v[p])
    );
  end

  ioc_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .change_i(change),
    .act_a_i(act_v[0]), .act_b_i(act_v[1]),
    .rd_a_i(rd_clr_a_i), .rd_b_i(rd_clr_b_i),
    .pol_i(irq_pol_i), .mirror_i(irq_mirror_i),
    .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
  );

  assign flags_a_o = flg_v[0];
  assign flags_b_o = flg_v[1];
  assign cap_a_o   = cap_v[0];
  assign cap_b_o   = cap_v[1];

  // R5: stored port value follows the synchronizer only on change
  p_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !change |=> $stable(prev_q[0]) && $stable(prev_q[1]));
endmodule

// File: tb/gpio_ioc_core_tb.sv
`timescale 1ns/1ps
module gpio_ioc_core_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pa = '0, pb = '0, en_a = '1, en_b = '1, md_a = '0, md_b = '0;
  logic [W-1:0] rf_a = '0, rf_b = '0, dr_a = '1, dr_b = '1;
  logic pol = 1'b1, mir = 1'b0, rd_a = 1'b0, rd_b = 1'b0;
  logic [W-1:0] fa, fb, ca, cb;
  logic ia, ib;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_ioc_core #(.PORT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_a_i(pa), .pins_b_i(pb),
    .irq_en_a_i(en_a), .irq_en_b_i(en_b),
    .cmp_ref_sel_a_i(md_a), .cmp_ref_sel_b_i(md_b),
    .ref_a_i(rf_a), .ref_b_i(rf_b), .dir_in_a_i(dr_a), .dir_in_b_i(dr_b),
    .irq_pol_i(pol), .irq_mirror_i(mir), .rd_clr_a_i(rd_a), .rd_clr_b_i(rd_b),
    .flags_a_o(fa), .flags_b_o(fb), .cap_a_o(ca), .cap_b_o(cb),
    .irq_a_o(ia), .irq_b_o(ib)
  );

  typedef struct packed {
    logic [7:0] pa, pb, md, rf, fa, ca, fb, cb;
    logic       ia, ib;
  } vec_t;

  // pol=0, mirror=0, all pins enabled inputs
  localparam vec_t VECS [5] = '{
    '{8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1},
    '{8'h03, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1},
    '{8'h03, 8'h80, 8'h00, 8'h00, 8'h00, 8'h01, 8'h80, 8'h80, 1'b1, 1'b0},
    '{8'h07, 8'h80, 8'h0F, 8'h0F, 8'h08, 8'h07, 8'h00, 8'h80, 1'b0, 1'b1},
    '{8'h17, 8'h80, 8'h0F, 8'h0F, 8'h18, 8'h07, 8'h00, 8'h80, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd(input bit a);
    @(negedge clk);
    if (a) rd_a = 1'b1; else rd_b = 1'b1;
    @(negedge clk);
    rd_a = 1'b0; rd_b = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs high after reset even with polarity 1
    chk("R1", "irq_a", {7'd0, ia}, 8'd1);
    chk("R1", "irq_b", {7'd0, ib}, 8'd1);
    chk("R1", "flags_a", fa, 8'h00);
    chk("R1", "cap_b", cb, 8'h00);
    pol = 1'b0;

    // R3 R6 R7: vector table
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pa = VECS[i].pa; pb = VECS[i].pb; md_a = VECS[i].md; rf_a = VECS[i].rf;
      step();
      chk("R3_R6", "flags_a", fa, VECS[i].fa);
      chk("R7", "cap_a", ca, VECS[i].ca);
      chk("R6", "flags_b", fb, VECS[i].fb);
      chk("R7", "cap_b", cb, VECS[i].cb);
      chk("R8", "irq_a", {7'd0, ia}, {7'd0, VECS[i].ia});
      chk("R8", "irq_b", {7'd0, ib}, {7'd0, VECS[i].ib});
    end

    // R10: read clear of port A
    pulse_rd(1'b1);
    chk("R10", "flags_a", fa, 8'h00);
    chk("R10", "irq_a", {7'd0, ia}, 8'd1);
    md_a = '0; rf_a = '0;

    // R2 R4: masks and synchronizer latency
    @(negedge clk);
    en_a = 8'h3C; dr_a = 8'h0F; pa = 8'hE8;
    repeat (2) @(posedge clk);
    #1 chk("R2", "flags_a early", fa, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R2_R4", "flags_a", fa, 8'h0C);
    chk("R7", "cap_a", ca, 8'hE8);
    chk("R8", "irq_a", {7'd0, ia}, 8'd0);

    // R5: configuration change alone
    md_a = 8'hFF; rf_a = 8'h00;
    step(); step();
    chk("R5", "flags_a", fa, 8'h0C);
    chk("R5", "irq_a", {7'd0, ia}, 8'd0);
    md_a = '0;

    // R12 R8: zero enable mask
    @(negedge clk);
    en_a = 8'h00; pa = 8'hE9;
    step();
    chk("R12", "flags_a", fa, 8'h0C);
    chk("R12", "cap_a", ca, 8'hE8);
    chk("R8", "irq_a inactive", {7'd0, ia}, 8'd1);
    en_a = '1; dr_a = '1;
    pulse_rd(1'b1);

    // R9: mirror
    @(negedge clk);
    mir = 1'b1; pb = 8'h81;
    step();
    chk("R9", "irq_a", {7'd0, ia}, 8'd0);
    chk("R9", "irq_b", {7'd0, ib}, 8'd0);
    chk("R7", "cap_b", cb, 8'h81);
    pulse_rd(1'b1);
    chk("R10", "mirror irq_a", {7'd0, ia}, 8'd1);
    chk("R10", "mirror irq_b", {7'd0, ib}, 8'd1);
    chk("R10", "flags_b kept", fb, 8'h01);

    // R8: polarity 1
    @(negedge clk);
    mir = 1'b0; pol = 1'b1; pb = 8'h83;
    step();
    chk("R8", "irq_b active high", {7'd0, ib}, 8'd1);
    chk("R8", "irq_a inactive low", {7'd0, ia}, 8'd0);
    chk("R7", "cap_b unchanged", cb, 8'h81);
    chk("R6", "flags_b", fb, 8'h02);

    // R11: read strobe on the evaluation cycle
    @(negedge clk);
    pb = 8'h87;
    repeat (2) @(posedge clk);
    @(negedge clk); rd_b = 1'b1;
    @(negedge clk); rd_b = 1'b0;
    chk("R11", "flags_b", fb, 8'h04);
    chk("R11", "cap_b", cb, 8'h87);
    chk("R11", "irq_b", {7'd0, ib}, 8'd1);
    pulse_rd(1'b0);
    chk("R10", "flags_b", fb, 8'h00);
    chk("R10", "irq_b", {7'd0, ib}, 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule